// File: doc/BRIEF.md
# Local Bus Strobe Timing Sequencer

This block runs one transfer on a multiplexed local bus. Each transfer can be a single beat or a burst. A requester offers an address, a direction, a burst length and a 32-bit timing descriptor for the target region, using a valid/ready handshake. The block then drives the bus-side control pins:

- an active-low direction level;
- separate read and write strobes;
- a write-data drive enable;
- an internal-wait indicator.

It samples the target's ready and burst-terminate inputs to decide when each beat completes.

The descriptor controls the timing of the transfer:

- a lead-in wait between address and first data;
- a gap wait between burst beats;
- how many clocks the strobe is held off inside the lead-in wait;
- for writes, how many clocks the write data stays driven after the strobe is released.

A one-cycle done pulse marks the end of the transfer. Only after it does the block take the next request. All control outputs come straight from registered state, so they change only on the rising clock edge.

Top module: `lbus_strobe_seq`

## Requirements
- R1: `bus_dir` and `bus_addr` take the request's direction and address when a request is accepted, and hold them until the next accept. `bus_dir` is 0 for a read and 1 for a write.
- R2: Descriptor layout:
  - read lead-in wait N in bits [4:0], write lead-in wait in [9:5];
  - read gap wait in [11:10], write gap wait in [13:12];
  - burst-terminate enable in bit 14;
  - read strobe delay in [27:26], write strobe delay in [29:28];
  - write hold in [31:30].
  
  Cycles are counted from cycle 1, the cycle after the accepting edge. Cycles 1..N are lead-in cycles. For a read, `rd_stb_n` is high in lead-in cycles 1..D and low from lead-in cycle D+1 onward, where D is the strobe delay.
- R3: For a write, `wr_stb_n` follows the same pattern with the write fields. At no time are both strobes low.
- R4: A strobe delay larger than the lead-in wait N is clamped to N. With such a delay, the strobe first goes low in the first beat cycle.
- R5: `iwait_n` is low in every lead-in and gap cycle, and high otherwise. `rdy_n` is ignored in those cycles.
- R6: After the lead-in comes a beat cycle. A beat completes in a beat cycle where `rdy_n` is sampled low. A burst has `req_beats`+1 beats. Between beats come gap-wait cycles, if any, and then the next beat cycle. The active strobe stays low from its first assertion through every beat and gap.
- R7: When descriptor bit 14 is 1, a low `bterm_n` in a beat cycle completes that beat and ends the burst, whatever `rdy_n` is. When bit 14 is 0, `bterm_n` has no effect.
- R8: For a write, `data_oe` is high from cycle 1 through the last beat. It then stays high for H further hold cycles with `wr_stb_n` high, where H is the write hold. For a read, `data_oe` is never high.
- R9: After the final beat and any hold cycles comes one cycle with `done` high and all strobes released. `req_ready` is high exactly in idle cycles, which start the cycle after `done`.
- R10: After reset:
  - `req_ready` = 1;
  - `rd_stb_n`, `wr_stb_n` and `iwait_n` = 1;
  - `done` and `data_oe` = 0;
  - `bus_dir` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to accept |
| req_addr | input | ADDR_W | Transfer address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_beats | input | BEAT_W | Number of beats minus one |
| req_desc | input | 32 | Region timing descriptor |
| bus_addr | output | ADDR_W | Latched address |
| bus_dir | output | 1 | Direction level, low for read |
| rd_stb_n | output | 1 | Read strobe, active low |
| wr_stb_n | output | 1 | Write strobe, active low |
| data_oe | output | 1 | Write data drive enable |
| iwait_n | output | 1 | Low while internal waits count |
| rdy_n | input | 1 | Target ready, active low |
| bterm_n | input | 1 | Burst terminate, active low |
| done | output | 1 | Transfer complete pulse |

## Verification
Every output is a decode of registered state. The effect of an accept, or of a ready or terminate sample, therefore appears in the cycle after that edge: cycle k of a transfer is cycle k after the accepting edge. The driver expands each request into one expected output word per cycle. It starts at cycle 1 and runs through the done cycle and one idle cycle. The driver also places ready and terminate levels exactly in the beat cycles that should consume them. Outputs are compared at mid-period, well after the edge that updates them. Ready is held low through every lead-in and gap cycle, so any early sampling shows up as a shifted word.

// File: rtl/lbus_seq_pkg.sv
package lbus_seq_pkg;

    localparam int WAIT_W = 5;
    localparam int SMALL_W = 2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_BEAT,
        PH_GAP,
        PH_HOLD,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic [WAIT_W-1:0]  lead;
        logic [SMALL_W-1:0] gap;
        logic [SMALL_W-1:0] dly;
        logic [SMALL_W-1:0] hold;
        logic               bt_en;
    } timing_t;

    function automatic timing_t pick_timing(input logic [31:0] d, input logic wr);
        timing_t t;
        logic [SMALL_W-1:0] raw;
        t.lead  = wr ? d[9:5]   : d[4:0];
        t.gap   = wr ? d[13:12] : d[11:10];
        raw     = wr ? d[29:28] : d[27:26];
        t.dly   = ({3'b000, raw} > t.lead) ? t.lead[SMALL_W-1:0] : raw;
        t.hold  = wr ? d[31:30] : 2'b00;
        t.bt_en = d[14];
        return t;
    endfunction

endpackage

// File: rtl/lbus_req_hold.sv
module lbus_req_hold
    import lbus_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BEAT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_write,
    input  logic [BEAT_W-1:0] in_beats,
    input  logic [31:0]       in_desc,
    output logic [ADDR_W-1:0] q_addr,
    output logic              q_write,
    output logic [BEAT_W-1:0] q_beats,
    output timing_t           q_tim
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_addr  <= '0;
            q_write <= 1'b0;
            q_beats <= '0;
            q_tim   <= '0;
        end else if (take) begin
            q_addr  <= in_addr;
            q_write <= in_write;
            q_beats <= in_beats;
            q_tim   <= pick_timing(in_desc, in_write);
        end
    end
endmodule

// File: rtl/lbus_phase_ctrl.sv
module lbus_phase_ctrl
    import lbus_seq_pkg::*;
#(
    parameter int BEAT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [BEAT_W-1:0] in_beats,
    input  timing_t           in_tim,
    input  timing_t           tim,
    input  logic              is_write,
    input  logic              rdy_n,
    input  logic              bterm_n,
    output phase_e            phase,
    output logic [WAIT_W-1:0] tick
);
    logic [BEAT_W-1:0] left;
    logic bt_hit, beat_end;

    assign bt_hit   = tim.bt_en & ~bterm_n;
    assign beat_end = ~rdy_n | bt_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            tick  <= '0;
            left  <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: if (take) begin
                    left  <= in_beats;
                    tick  <= '0;
                    phase <= (in_tim.lead == '0) ? PH_BEAT : PH_LEAD;
                end
                PH_LEAD: begin
                    if (tick == tim.lead - 1'b1) begin
                        tick  <= '0;
                        phase <= PH_BEAT;
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                PH_BEAT: if (beat_end) begin
                    tick <= '0;
                    if (left == '0 || bt_hit) begin
                        phase <= (is_write && tim.hold != '0) ? PH_HOLD : PH_DONE;
                    end else begin
                        left  <= left - 1'b1;
                        phase <= (tim.gap == '0) ? PH_BEAT : PH_GAP;
                    end
                end
                PH_GAP: begin
                    if (tick == {3'b000, tim.gap} - 1'b1) begin
                        tick  <= '0;
                        phase <= PH_BEAT;
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (tick == {3'b000, tim.hold} - 1'b1) begin
                        tick  <= '0;
                        phase <= PH_DONE;
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                PH_DONE: phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lbus_pin_decode.sv
module lbus_pin_decode
    import lbus_seq_pkg::*;
(
    input  phase_e            phase,
    input  logic [WAIT_W-1:0] tick,
    input  timing_t           tim,
    input  logic              is_write,
    output logic              rd_stb_n,
    output logic              wr_stb_n,
    output logic              data_oe,
    output logic              iwait_n,
    output logic              done,
    output logic              idle
);
    logic stb_on, busy;

    always_comb begin
        stb_on = (phase == PH_BEAT) || (phase == PH_GAP) ||
                 ((phase == PH_LEAD) && (tick >= {3'b000, tim.dly}));
        busy   = (phase == PH_LEAD) || (phase == PH_BEAT) ||
                 (phase == PH_GAP)  || (phase == PH_HOLD);
        rd_stb_n = ~(stb_on & ~is_write);
        wr_stb_n = ~(stb_on & is_write);
        data_oe  = busy & is_write;
        iwait_n  = ~((phase == PH_LEAD) || (phase == PH_GAP));
        done     = (phase == PH_DONE);
        idle     = (phase == PH_IDLE);
    end
endmodule

// File: rtl/lbus_strobe_seq.sv
module lbus_strobe_seq
    import lbus_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BEAT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [BEAT_W-1:0] req_beats,
    input  logic [31:0]       req_desc,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_dir,
    output logic              rd_stb_n,
    output logic              wr_stb_n,
    output logic              data_oe,
    output logic              iwait_n,
    input  logic              rdy_n,
    input  logic              bterm_n,
    output logic              done
);
    logic              take;
    logic [BEAT_W-1:0] q_beats;
    timing_t           q_tim;
    timing_t           new_tim;
    phase_e            phase;
    logic [WAIT_W-1:0] tick;

    assign take    = req_valid & req_ready;
    assign new_tim = pick_timing(req_desc, req_write);

    lbus_req_hold #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_hold (
        .clk(clk), .rst(rst), .take(take),
        .in_addr(req_addr), .in_write(req_write), .in_beats(req_beats), .in_desc(req_desc),
        .q_addr(bus_addr), .q_write(bus_dir), .q_beats(q_beats), .q_tim(q_tim)
    );

    lbus_phase_ctrl #(.BEAT_W(BEAT_W)) u_ctrl (
        .clk(clk), .rst(rst), .take(take), .in_beats(req_beats), .in_tim(new_tim),
        .tim(q_tim), .is_write(bus_dir), .rdy_n(rdy_n), .bterm_n(bterm_n),
        .phase(phase), .tick(tick)
    );

    lbus_pin_decode u_pins (
        .phase(phase), .tick(tick), .tim(q_tim), .is_write(bus_dir),
        .rd_stb_n(rd_stb_n), .wr_stb_n(wr_stb_n), .data_oe(data_oe),
        .iwait_n(iwait_n), .done(done), .idle(req_ready)
    );

    logic unused_beats;
    assign unused_beats = ^q_beats;
endmodule

// File: rtl/lbus_strobe_seq_chk.sv
module lbus_strobe_seq_chk (
    input logic clk,
    input logic rst,
    input logic req_ready,
    input logic bus_dir,
    input logic rd_stb_n,
    input logic wr_stb_n,
    input logic data_oe,
    input logic iwait_n,
    input logic done
);
    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(!rd_stb_n && !wr_stb_n));

    assert_dir_stable_R1: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> $stable(bus_dir));

    assert_wait_no_done_R5: assert property (@(posedge clk) disable iff (rst)
        !iwait_n |=> !done);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && req_ready));

    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (rd_stb_n && wr_stb_n && !data_oe));

    assert_wr_drives_R8: assert property (@(posedge clk) disable iff (rst)
        !wr_stb_n |-> data_oe);

    assert_rd_no_drive_R8: assert property (@(posedge clk) disable iff (rst)
        !rd_stb_n |-> !data_oe);
endmodule

bind lbus_strobe_seq lbus_strobe_seq_chk u_chk (
    .clk(clk), .rst(rst), .req_ready(req_ready), .bus_dir(bus_dir),
    .rd_stb_n(rd_stb_n), .wr_stb_n(wr_stb_n), .data_oe(data_oe),
    .iwait_n(iwait_n), .done(done)
);

// File: tb/sim_lbus_strobe_seq.sv
`timescale 1ns/1ps
module sim_lbus_strobe_seq;
    localparam int ADDR_W = 32;
    localparam int BEAT_W = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic req_write = 1'b0;
    logic [BEAT_W-1:0] req_beats = '0;
    logic [31:0] req_desc = '0;
    logic [ADDR_W-1:0] bus_addr;
    logic bus_dir, rd_stb_n, wr_stb_n, data_oe, iwait_n, done;
    logic rdy_n = 1'b1;
    logic bterm_n = 1'b1;

    always #10 clk = ~clk;

    lbus_strobe_seq #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_beats(req_beats),
        .req_desc(req_desc), .bus_addr(bus_addr), .bus_dir(bus_dir),
        .rd_stb_n(rd_stb_n), .wr_stb_n(wr_stb_n), .data_oe(data_oe),
        .iwait_n(iwait_n), .rdy_n(rdy_n), .bterm_n(bterm_n), .done(done)
    );

    typedef struct {
        logic [ADDR_W-1:0] addr;
        logic dir, rd, wr, oe, wt, dn, rr;
    } exp_t;

    exp_t exp_q[$];
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic check1(input string tag, input logic act, input logic expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s act=%b exp=%b at %0t", tag, act, expv, $time);
        end
    endtask

    // monitor: compares one expected word per cycle at mid-period
    always @(negedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_chk++;
            if (bus_addr !== e.addr) begin
                n_bad++;
                $display("FAIL R1 addr act=%h exp=%h", bus_addr, e.addr);
            end
            check1("R1 bus_dir",   bus_dir,   e.dir);
            check1("R2 rd_stb_n",  rd_stb_n,  e.rd);
            check1("R3 wr_stb_n",  wr_stb_n,  e.wr);
            check1("R8 data_oe",   data_oe,   e.oe);
            check1("R5 iwait_n",   iwait_n,   e.wt);
            check1("R9 done",      done,      e.dn);
            check1("R9 req_ready", req_ready, e.rr);
        end
    end

    function automatic exp_t mk(input logic [ADDR_W-1:0] a, input logic w,
                                input logic stb, input logic oe, input logic wt,
                                input logic dn, input logic rr);
        exp_t e;
        e.addr = a; e.dir = w;
        e.rd = ~(stb & ~w); e.wr = ~(stb & w);
        e.oe = oe; e.wt = wt; e.dn = dn; e.rr = rr;
        return e;
    endfunction

    task automatic step(input exp_t e, input logic r, input logic b);
        exp_q.push_back(e);
        rdy_n = r;
        bterm_n = b;
        @(negedge clk);
    endtask

    // btmode: 0 plain, 1 terminate (enabled) at beat btb, 2 terminate pulses while disabled
    task automatic run(input logic w, input logic [ADDR_W-1:0] a, input int beats,
                       input int lead, input int gap, input int dly, input int hold,
                       input logic bten, input int lat, input int btmode, input int btb);
        logic [31:0] d;
        int dc;
        bit stop;
        d = '0;
        if (w) begin
            d[9:5] = 5'(lead); d[13:12] = 2'(gap); d[29:28] = 2'(dly); d[31:30] = 2'(hold);
        end else begin
            d[4:0] = 5'(lead); d[11:10] = 2'(gap); d[27:26] = 2'(dly);
        end
        d[14] = bten;
        dc = (dly > lead) ? lead : dly;   // R4 clamp
        req_valid = 1'b1; req_write = w; req_addr = a;
        req_beats = BEAT_W'(beats); req_desc = d;
        @(negedge clk);
        req_valid = 1'b0;
        // lead-in cycles: ready held low to prove it is masked (R5)
        for (int c = 0; c < lead; c++)
            step(mk(a, w, (c >= dc), w, 1'b0, 1'b0, 1'b0), 1'b0, 1'b1);
        stop = 0;
        for (int b = 0; b <= beats && !stop; b++) begin
            int l;
            l = lat + (b & 1);
            for (int k = 0; k <= l; k++) begin
                logic r, bt;
                r = 1'b1; bt = 1'b1;
                if (btmode == 1 && b == btb) begin
                    if (k == l) bt = 1'b0;          // R7 terminate, ready high
                end else begin
                    if (k == l) r = 1'b0;           // R6 beat completes
                    if (btmode == 2 && k < l) bt = 1'b0; // R7 ignored when disabled
                end
                step(mk(a, w, 1'b1, w, 1'b1, 1'b0, 1'b0), r, bt);
            end
            if ((btmode == 1 && b == btb) || b == beats) stop = 1;
            else
                for (int g = 0; g < gap; g++)
                    step(mk(a, w, 1'b1, w, 1'b0, 1'b0, 1'b0), 1'b0, 1'b1);
        end
        if (w)
            for (int h = 0; h < hold; h++)
                step(mk(a, w, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0), 1'b0, 1'b1);
        step(mk(a, w, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0), 1'b1, 1'b1);  // R9 done cycle
        step(mk(a, w, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1), 1'b1, 1'b1);  // idle
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        check1("R10 req_ready", req_ready, 1'b1);
        check1("R10 rd_stb_n", rd_stb_n, 1'b1);
        check1("R10 wr_stb_n", wr_stb_n, 1'b1);
        check1("R10 iwait_n", iwait_n, 1'b1);
        check1("R10 done", done, 1'b0);
        check1("R10 data_oe", data_oe, 1'b0);
        check1("R10 bus_dir", bus_dir, 1'b0);
        @(negedge clk);
        // R2 R6 read burst, delayed strobe, gaps
        run(1'b0, 32'h1000_0040, 2, 3, 1, 1, 0, 1'b0, 0, 0, 0);
        // R3 R8 write burst with hold
        run(1'b1, 32'h2000_0010, 1, 2, 2, 2, 2, 1'b0, 1, 0, 0);
        // R6 zero-wait single read
        run(1'b0, 32'h0000_0004, 0, 0, 0, 0, 0, 1'b0, 0, 0, 0);
        // R4 delay clamped to lead-in
        run(1'b0, 32'h0000_0100, 0, 1, 0, 3, 0, 1'b0, 0, 0, 0);
        // R7 enabled terminate ends write burst early, then hold
        run(1'b1, 32'h3000_0000, 3, 1, 1, 0, 1, 1'b1, 1, 1, 1);
        // R7 terminate ignored when disabled
        run(1'b0, 32'h4000_0008, 1, 2, 1, 0, 0, 1'b0, 2, 2, 0);
        // R8 zero lead-in write with long hold
        run(1'b1, 32'h5000_0020, 0, 0, 0, 0, 3, 1'b0, 0, 0, 0);
        // R3 write with long lead-in and delay
        run(1'b1, 32'h6000_0000, 1, 5, 0, 3, 0, 1'b0, 0, 0, 0);
        repeat (2) @(negedge clk);
        finished = 1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
        end
    end
endmodule